// File: doc/BRIEF.md
# Programmable Pixel Clock Generator

This block derives a pixel clock and a one-tick data-launch strobe from a timebase running at twice the master clock rate. One tick of that timebase is half a master clock cycle. A 4-bit speed setting N gives a pixel period of 2×N master cycles, which is 4×N ticks. A speed of zero behaves as one. A 4-bit delay setting moves the pixel clock edges later by whole ticks, wrapped modulo the period. An invert setting swaps which edge sits at the delayed launch point.

The launch strobe marks the undelayed start of every pixel period, which is where data and valid signals would change. The pixel clock is placed relative to that point. New settings are taken in only when a period ends, so a period is never cut short or stretched partway through. A readback output returns the effective speed: the speed input, with zero shown as one.

Top module: `pixclk_gen`

## Requirements
- R1: With an effective speed of N, the pixel clock rises exactly once every 4×N ticks of `clk2x`.
- R2: A speed input of 0 gives the same period as a speed of 1. `readSpeed` always equals `speedIn`, except that an input of 0 reads back as 1.
- R3: Let the phase p be the tick count since the undelayed period start, 0 to 4N−1, and let D be the delay. With invert clear, the pixel clock is high when ((p − D) mod 4N) < 2N and low otherwise. Its rising edge therefore sits D mod 4N ticks after the launch point.
- R4: With invert set, the pixel clock is the complement of the R3 waveform, so its falling edge sits at the delayed launch point.
- R5: While `rst` is high at a clock edge, `pixClk` and `launchStb` are 0 after that edge. The settings in use return to speed 1, delay 0 and invert clear, and the phase returns to 0.
- R6: `launchStb` is high for exactly one tick per period, at phase 0. Both outputs are registered and show the phase of the previous tick.
- R7: Speed, delay and invert are sampled only on the last tick of a period (phase 4N−1). Changes at any other time do not affect the current period.
- R8: A delay of 4N or more acts as the delay modulo 4N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Timebase at twice the master rate; one tick is one half-master-cycle |
| rst | input | 1 | Synchronous reset, active high |
| speedIn | input | 4 | Period setting N; period is 4×N ticks, 0 treated as 1 |
| delayIn | input | 4 | Edge delay in ticks, wrapped modulo the period |
| invertIn | input | 1 | When set, the delayed launch point aligns to a falling edge |
| pixClk | output | 1 | Registered pixel clock |
| launchStb | output | 1 | One-tick strobe at the undelayed period start |
| readSpeed | output | 4 | Effective speed setting |

## Verification
Both outputs come from one register stage after the phase counter. The bench's model therefore steps once per rising edge, and each result is compared at the following falling edge against the phase the counter held before that edge. A new setting first shapes the output one tick after the period boundary that samples it. The bench waits for that boundary plus one full period before it measures rising-edge spacing. `readSpeed` is combinational and is compared in the same tick as the input that drives it.

// File: rtl/pixclk_pkg.sv
package pixclk_pkg;

  // Per-tick signals passed from control to the output datapath.
  typedef struct packed {
    logic launch;   // undelayed period start (phase 0)
    logic clkHigh;  // un-inverted level of the pixel clock for this phase
    logic invert;   // invert setting currently in use
  } pclkStrobe_t;

endpackage

// File: rtl/pclk_ctrl.sv
module pclk_ctrl
  import pixclk_pkg::*;
#(
  parameter int SPEED_W = 4,
  parameter int DELAY_W = 4
) (
  input  logic               clk2x,
  input  logic               rst,
  input  logic [SPEED_W-1:0] speedIn,
  input  logic [DELAY_W-1:0] delayIn,
  input  logic               invertIn,
  output logic [SPEED_W-1:0] readSpeed,
  output pclkStrobe_t        strb
);

  localparam int MAX_TICKS = 4 * ((1 << SPEED_W) - 1);
  localparam int PH_W      = $clog2(MAX_TICKS + 1);
  localparam int CW        = ((PH_W > DELAY_W) ? PH_W : DELAY_W) + 1;

  logic [PH_W-1:0]    phase;
  logic [PH_W-1:0]    periodTicks;
  logic [PH_W-1:0]    halfTicks;
  logic [PH_W-1:0]    dMod;
  logic [PH_W-1:0]    shifted;
  logic [CW-1:0]      dWide;
  logic [SPEED_W-1:0] speedAct;
  logic [SPEED_W-1:0] speedEff;
  logic [DELAY_W-1:0] delayAct;
  logic               invAct;
  logic               lastPhase;

  // Zero speed behaves as one.
  assign speedEff  = (speedIn == '0) ? SPEED_W'(1) : speedIn;
  assign readSpeed = speedEff;

  assign periodTicks = PH_W'(speedAct) << 2;
  assign halfTicks   = PH_W'(speedAct) << 1;
  assign lastPhase   = (phase == periodTicks - PH_W'(1));

  // Delay wrapped into one period, then subtracted from the phase modulo the period.
  assign dWide   = CW'(delayAct) % CW'(periodTicks);
  assign dMod    = PH_W'(dWide);
  assign shifted = (phase >= dMod) ? (phase - dMod) : (phase + periodTicks - dMod);

  always_comb begin
    strb.launch  = (phase == '0);
    strb.clkHigh = (shifted < halfTicks);
    strb.invert  = invAct;
  end

  // Phase counter. Settings are reloaded only on the period's final tick.
  always_ff @(posedge clk2x) begin
    if (rst) begin
      phase    <= '0;
      speedAct <= SPEED_W'(1);
      delayAct <= '0;
      invAct   <= 1'b0;
    end else if (lastPhase) begin
      phase    <= '0;
      speedAct <= speedEff;
      delayAct <= delayIn;
      invAct   <= invertIn;
    end else begin
      phase    <= phase + PH_W'(1);
    end
  end

  // R1
  phase_range_chk: assert property (@(posedge clk2x) disable iff (rst)
    phase < periodTicks);

  // R7
  cfg_hold_chk: assert property (@(posedge clk2x) disable iff (rst)
    (phase != '0) |-> ($stable(speedAct) && $stable(delayAct) && $stable(invAct)));

  // R2
  active_nonzero_chk: assert property (@(posedge clk2x) disable iff (rst)
    speedAct != '0);

endmodule

// File: rtl/pclk_dp.sv
module pclk_dp
  import pixclk_pkg::*;
(
  input  logic        clk2x,
  input  logic        rst,
  input  pclkStrobe_t strb,
  output logic        pixClk,
  output logic        launchStb
);

  always_ff @(posedge clk2x) begin
    if (rst) begin
      pixClk    <= 1'b0;
      launchStb <= 1'b0;
    end else begin
      pixClk    <= strb.clkHigh ^ strb.invert;
      launchStb <= strb.launch;
    end
  end

  // R5
  reset_idle_chk: assert property (@(posedge clk2x) disable iff (rst)
    $past(rst) |-> (!pixClk && !launchStb));

  // R6
  launch_single_chk: assert property (@(posedge clk2x) disable iff (rst)
    launchStb |=> !launchStb);

endmodule

// File: rtl/pixclk_gen.sv
module pixclk_gen
  import pixclk_pkg::*;
#(
  parameter int SPEED_W = 4,
  parameter int DELAY_W = 4
) (
  input  logic               clk2x,
  input  logic               rst,
  input  logic [SPEED_W-1:0] speedIn,
  input  logic [DELAY_W-1:0] delayIn,
  input  logic               invertIn,
  output logic               pixClk,
  output logic               launchStb,
  output logic [SPEED_W-1:0] readSpeed
);

  pclkStrobe_t strb;

  pclk_ctrl #(.SPEED_W(SPEED_W), .DELAY_W(DELAY_W)) u_ctrl (
    .clk2x    (clk2x),
    .rst      (rst),
    .speedIn  (speedIn),
    .delayIn  (delayIn),
    .invertIn (invertIn),
    .readSpeed(readSpeed),
    .strb     (strb)
  );

  pclk_dp u_dp (
    .clk2x    (clk2x),
    .rst      (rst),
    .strb     (strb),
    .pixClk   (pixClk),
    .launchStb(launchStb)
  );

  // R2
  readback_nonzero_chk: assert property (@(posedge clk2x) disable iff (rst)
    readSpeed != '0);

  // R2
  readback_match_chk: assert property (@(posedge clk2x) disable iff (rst)
    (speedIn != '0) |-> (readSpeed == speedIn));

endmodule

// File: tb/pixclk_gen_bench.sv
module pixclk_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk2x = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] speedIn = '0;
  logic [3:0] delayIn = '0;
  logic       invertIn = 1'b0;
  logic       pixClk;
  logic       launchStb;
  logic [3:0] readSpeed;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Model state: settings in use, phase, expected registered outputs.
  int mPhase = 0, mSpd = 1, mDel = 0, mInv = 0;
  int expClk = 0, expLaunch = 0;
  int cyc = 0;
  int prevClk = 0;
  bit recording = 0;
  int firstRise = -1, secondRise = -1;

  always #(CLK_PERIOD/2) clk2x = ~clk2x;

  pixclk_gen u_pixclk_gen (
    .clk2x    (clk2x),
    .rst      (rst),
    .speedIn  (speedIn),
    .delayIn  (delayIn),
    .invertIn (invertIn),
    .pixClk   (pixClk),
    .launchStb(launchStb),
    .readSpeed(readSpeed)
  );

  function automatic int effOf(int s);
    return (s == 0) ? 1 : s;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // One tick: the model follows the rising edge, and the outputs are compared at the falling edge.
  task automatic step();
    int p, sh;
    @(negedge clk2x);
    if (rst) begin
      mPhase = 0; mSpd = 1; mDel = 0; mInv = 0;
      expClk = 0; expLaunch = 0;
      check(pixClk == 1'b0 && launchStb == 1'b0, "R5", {pixClk, launchStb}, 0);
    end else begin
      p  = 4 * mSpd;
      sh = ((mPhase - (mDel % p)) + p) % p;
      expClk    = ((sh < 2 * mSpd) ? 1 : 0) ^ mInv;
      expLaunch = (mPhase == 0) ? 1 : 0;
      if (mPhase == p - 1) begin
        mPhase = 0;
        mSpd = effOf(int'(speedIn));
        mDel = int'(delayIn);
        mInv = int'(invertIn);
      end else begin
        mPhase++;
      end
    end
    check(int'(pixClk) == expClk, "R3 R4 R7 R8 pixClk", int'(pixClk), expClk);
    check(int'(launchStb) == expLaunch, "R6 launchStb", int'(launchStb), expLaunch);
    check(int'(readSpeed) == effOf(int'(speedIn)), "R2 readSpeed",
          int'(readSpeed), effOf(int'(speedIn)));
    if (recording && pixClk && prevClk == 0) begin
      if (firstRise < 0) firstRise = cyc;
      else if (secondRise < 0) secondRise = cyc;
    end
    prevClk = int'(pixClk);
    cyc++;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk2x);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    // R5: the reset state
    repeat (3) step();

    rst = 1'b0;
    // Full sweep of speed, delay and invert
    for (int s = 0; s < 16; s++) begin
      for (int d = 0; d < 16; d++) begin
        for (int v = 0; v < 2; v++) begin
          int pe;
          speedIn  = 4'(s);
          delayIn  = 4'(d);
          invertIn = v[0];
          pe = 4 * effOf(s);
          // Wait for the boundary that loads this setting, then one settling period.
          do step(); while (!(mPhase == 0 && mSpd == effOf(s) && mDel == d && mInv == v));
          repeat (pe) step();
          firstRise = -1; secondRise = -1; recording = 1;
          repeat (2 * pe + 1) step();
          recording = 0;
          // R1, with R2 covering speed 0: the spacing between rising edges
          check(secondRise - firstRise == pe, "R1 R2 period", secondRise - firstRise, pe);
        end
      end
    end

    // R7: settings change mid-period; the model applies them only at boundaries
    for (int k = 0; k < 300; k++) begin
      if (k % 3 == 0) begin
        speedIn  = 4'((k * 7 + 3) % 16);
        delayIn  = 4'((k * 5 + 1) % 16);
        invertIn = k[2];
      end
      step();
    end

    // R5: reset partway through a period
    speedIn = 4'd5; delayIn = 4'd9; invertIn = 1'b1;
    repeat (7) step();
    rst = 1'b1;
    repeat (2) step();
    rst = 1'b0;
    repeat (60) step();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule